// File: doc/BRIEF.md
# Multichannel Double-Buffered DAC Register Bank with Gain/Offset Correction

This block holds the digital state of a 40-channel voltage DAC. Already-decoded write transactions come in. Each one carries a channel address, a two-bit register select and a 14-bit word. The select steers the word into the addressed channel's input register, offset register or gain register. Select `00` is reserved for a separate set of device-wide registers, which are not part of this block. For those writes the block only raises a flag.

The channel outputs are double buffered. Writes never move the DAC codes directly. A rising edge on the load input starts an update pass. During the pass, one shared corrector walks the channels one at a time. For each channel it computes `((gain + 2) * input) / 2^14 + offset - 2^13`, clamps the result to the code range and places it in a shadow set. When every channel is done, the whole DAC code set is replaced in a single cycle, so all channel outputs move together.

If a load edge arrives during a pass, it is remembered, and a second pass follows straight away. Writes to channel numbers that do not exist are dropped and reported with a one-cycle error pulse.

Top module: `dacbank_top`

## Requirements
- R1: A write with select `11` stores the 14-bit word in the addressed channel's input register. The DAC code of that channel does not change until a later update pass.
- R2: Select `10` stores the word in the channel's offset register. Select `01` stores it in the channel's gain register with bit 0 forced to 0.
- R3: After reset, every input register is 0, every gain register is 0x3FFE, every offset register is 0x2000, every DAC code is 0, and `busy`, `addr_err` and `sfr_wr` are low.
- R4: An update pass gives each channel the code `floor((gain+2)*input/16384) + offset - 8192`. The code is clamped to 0 when negative and to 16383 when above 16383.
- R5: A write with select `00`, at any address, changes no channel register. It raises `sfr_wr` for exactly the cycle after the write edge and never raises `addr_err`.
- R6: A write with select other than `00` to a channel number of 40 or more changes nothing. It raises `addr_err` for exactly the cycle after the write edge.
- R7: A clock edge that samples `load` high after sampling it low the edge before starts a pass. `busy` is high from that edge for exactly NCH+1 cycles. All DAC codes take their new values at the edge where `busy` falls.
- R8: `dac_codes` changes only at the final edge of a pass, never while the block is idle.
- R9: One or more load rising edges seen during a pass cause exactly one further pass, which begins without an idle cycle. Two back-to-back passes keep `busy` high for 2*(NCH+1) cycles.
- R10: Holding `load` high does not start further passes. Only a new low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write transaction valid this cycle |
| wr_chan | input | AW (6) | Channel address of the write |
| wr_sel | input | 2 | Register select: 11 input, 10 offset, 01 gain, 00 device-wide |
| wr_data | input | DW (14) | Write data word |
| load | input | 1 | Load request, acted on at its rising edge |
| dac_codes | output | NCH*DW (560) | Committed DAC codes, channel k at bits [k*DW +: DW] |
| busy | output | 1 | Update pass in progress |
| addr_err | output | 1 | One-cycle pulse after a write to a missing channel |
| sfr_wr | output | 1 | One-cycle pulse after a select-00 write |

## Verification
The hardest case to reach is a load edge that arrives during a pass, combined with a register change that only the second pass can pick up. The stimulus raises `load` twice while a pass runs. It then rewrites channel 0 after the first pass has already computed channel 0. The final codes show that the queued pass ran in full, and the busy window shows that it ran only once. Clamping at both ends and the forced-zero gain bit are set up with directed writes. The random writes include missing channels and select `00`.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    typedef enum logic [1:0] {
        SEL_SFR  = 2'b00,
        SEL_GAIN = 2'b01,
        SEL_OFFS = 2'b10,
        SEL_DATA = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_RUN    = 2'd1,
        PH_COMMIT = 2'd2
    } phase_e;

endpackage

// File: rtl/dacbank_corr.sv
module dacbank_corr #(
    parameter int DW = 14
) (
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] gain,
    input  logic [DW-1:0] offs,
    output logic [DW-1:0] y_out
);
    localparam int PW   = 2 * DW + 1;
    localparam int SW   = DW + 3;
    localparam int HALF = 1 << (DW - 1);
    localparam int MAXC = (1 << DW) - 1;

    logic [PW-1:0]       prod;
    logic [DW:0]         scaled;
    logic signed [SW-1:0] sum;

    always_comb begin
        prod   = (PW'(gain) + PW'(2)) * PW'(x_in);
        scaled = prod[2*DW:DW];
        sum    = $signed({2'b00, scaled}) + $signed({3'b000, offs}) - $signed(SW'(HALF));
        if (sum < 0) begin
            y_out = '0;
        end else if (sum > $signed(SW'(MAXC))) begin
            y_out = '1;
        end else begin
            y_out = sum[DW-1:0];
        end
    end
endmodule

// File: rtl/dacbank_seq.sv
module dacbank_seq
    import dacbank_pkg::*;
#(
    parameter int NCH = 40,
    parameter int IW  = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    output logic          busy,
    output logic          calc_en,
    output logic [IW-1:0] calc_idx,
    output logic          commit
);
    typedef struct packed {
        phase_e        ph;
        logic          load_q;
        logic          pend;
        logic [IW-1:0] idx;
    } seq_t;

    seq_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d        = st_q;
        st_d.load_q = load;
        rise        = load & ~st_q.load_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (rise) begin
                    st_d.ph  = PH_RUN;
                    st_d.idx = '0;
                end
            end
            PH_RUN: begin
                if (rise) st_d.pend = 1'b1;
                if (st_q.idx == IW'(NCH - 1)) begin
                    st_d.ph = PH_COMMIT;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            PH_COMMIT: begin
                if (st_q.pend || rise) begin
                    st_d.ph   = PH_RUN;
                    st_d.idx  = '0;
                    st_d.pend = 1'b0;
                end else begin
                    st_d.ph = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, load_q: 1'b0, pend: 1'b0, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.ph != PH_IDLE);
    assign calc_en  = (st_q.ph == PH_RUN);
    assign calc_idx = st_q.idx;
    assign commit   = (st_q.ph == PH_COMMIT);
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
    import dacbank_pkg::*;
#(
    parameter int NCH       = 40,
    parameter int DW        = 14,
    parameter int AW        = 6,
    parameter int GAIN_INIT = 16'h3FFE,
    parameter int OFFS_INIT = 16'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_chan,
    input  logic [1:0]        wr_sel,
    input  logic [DW-1:0]     wr_data,
    input  logic              load,
    output logic [NCH*DW-1:0] dac_codes,
    output logic              busy,
    output logic              addr_err,
    output logic              sfr_wr
);
    localparam int IW = $clog2(NCH);

    typedef struct {
        logic [DW-1:0] inp  [NCH];
        logic [DW-1:0] gain [NCH];
        logic [DW-1:0] offs [NCH];
        logic [DW-1:0] shad [NCH];
        logic [DW-1:0] dac  [NCH];
        logic          err;
        logic          sfr;
    } bank_t;

    bank_t bank_d, bank_q;

    logic          calc_en, commit;
    logic [IW-1:0] calc_idx;
    logic [DW-1:0] corr_y;
    logic [IW-1:0] ch;
    logic          ch_ok;

    dacbank_seq #(.NCH(NCH), .IW(IW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .busy     (busy),
        .calc_en  (calc_en),
        .calc_idx (calc_idx),
        .commit   (commit)
    );

    dacbank_corr #(.DW(DW)) u_corr (
        .x_in  (bank_q.inp[calc_idx]),
        .gain  (bank_q.gain[calc_idx]),
        .offs  (bank_q.offs[calc_idx]),
        .y_out (corr_y)
    );

    assign ch    = wr_chan[IW-1:0];
    assign ch_ok = (int'(wr_chan) < NCH);

    always_comb begin
        bank_d     = bank_q;
        bank_d.err = 1'b0;
        bank_d.sfr = 1'b0;
        if (wr_en) begin
            if (sel_e'(wr_sel) == SEL_SFR) begin
                bank_d.sfr = 1'b1;
            end else if (!ch_ok) begin
                bank_d.err = 1'b1;
            end else begin
                case (sel_e'(wr_sel))
                    SEL_DATA: bank_d.inp[ch]  = wr_data;
                    SEL_OFFS: bank_d.offs[ch] = wr_data;
                    SEL_GAIN: bank_d.gain[ch] = {wr_data[DW-1:1], 1'b0};
                    default:  ;
                endcase
            end
        end
        if (calc_en) begin
            bank_d.shad[calc_idx] = corr_y;
        end
        if (commit) begin
            for (int i = 0; i < NCH; i++) begin
                bank_d.dac[i] = bank_q.shad[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                bank_q.inp[i]  <= '0;
                bank_q.gain[i] <= DW'(GAIN_INIT);
                bank_q.offs[i] <= DW'(OFFS_INIT);
                bank_q.shad[i] <= '0;
                bank_q.dac[i]  <= '0;
            end
            bank_q.err <= 1'b0;
            bank_q.sfr <= 1'b0;
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign dac_codes[g*DW +: DW] = bank_q.dac[g];
    end

    assign addr_err = bank_q.err;
    assign sfr_wr   = bank_q.sfr;
endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk #(
    parameter int NCH = 40,
    parameter int DW  = 14,
    parameter int AW  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_chan,
    input logic [1:0]        wr_sel,
    input logic              load,
    input logic [NCH*DW-1:0] dac_codes,
    input logic              busy,
    input logic              addr_err,
    input logic              sfr_wr
);
    // R6: an error pulse follows only a non-00 write to a missing channel
    a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> $past(wr_en && wr_sel != 2'b00 && int'(wr_chan) >= NCH));

    // R5: the device-wide flag follows only a select-00 write
    a_r5_sfr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |-> $past(wr_en && wr_sel == 2'b00));

    // R5: a select-00 write never reports an address error
    a_r5_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_err, sfr_wr}));

    // R8: the codes stay put unless a pass was running before the edge
    a_r8_dac_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable(dac_codes));

    // R7: a load rise seen while idle starts a pass
    a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(load) && !busy) |=> busy);
endmodule

bind dacbank_top dacbank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_chan   (wr_chan),
    .wr_sel    (wr_sel),
    .load      (load),
    .dac_codes (dac_codes),
    .busy      (busy),
    .addr_err  (addr_err),
    .sfr_wr    (sfr_wr)
);

// File: tb/dacbank_top_tb.sv
module dacbank_top_tb;
    localparam int NCH = 40;
    localparam int DW  = 14;
    localparam int AW  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_chan = '0;
    logic [1:0]        wr_sel = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              load = 1'b0;
    logic [NCH*DW-1:0] dac_codes;
    logic              busy, addr_err, sfr_wr;

    int n_vec = 0;
    int n_bad = 0;
    int m_in [NCH];
    int m_gain [NCH];
    int m_off [NCH];
    int m_dac [NCH];

    always #2.5 clk = ~clk;

    dacbank_top #(.NCH(NCH), .DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_sel(wr_sel), .wr_data(wr_data), .load(load),
        .dac_codes(dac_codes), .busy(busy), .addr_err(addr_err), .sfr_wr(sfr_wr)
    );

    function automatic int corr(int x, int g, int c);
        int s;
        s = (((g + 2) * x) >>> 14) + c - 8192;
        if (s < 0) s = 0;
        if (s > 16383) s = 16383;
        return s;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cmp_all(string req);
        for (int i = 0; i < NCH; i++) begin
            chk(req, int'(dac_codes[i*DW +: DW]), m_dac[i]);
        end
    endtask

    // write, then look at the flags in the cycle after the write edge
    task automatic wr(int c, int s, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = AW'(c); wr_sel = 2'(s); wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
        if (s == 0) begin
            chk("R5 sfr_wr", int'(sfr_wr), 1);
            chk("R5 addr_err", int'(addr_err), 0);
        end else if (c >= NCH) begin
            chk("R6 addr_err", int'(addr_err), 1);
            chk("R6 sfr_wr", int'(sfr_wr), 0);
        end else begin
            chk("R1 flags quiet", int'(addr_err | sfr_wr), 0);
            if (s == 3) m_in[c] = d;
            else if (s == 2) m_off[c] = d;
            else m_gain[c] = d & 16'h3FFE;
        end
    endtask

    task automatic update_model();
        for (int i = 0; i < NCH; i++) m_dac[i] = corr(m_in[i], m_gain[i], m_off[i]);
    endtask

    // single pass with load held high afterwards to check no re-trigger
    task automatic do_load();
        int blen;
        @(negedge clk);
        load = 1'b1;
        blen = 0;
        @(negedge clk);
        while (busy) begin
            blen++;
            @(negedge clk);
        end
        chk("R7 busy length", blen, NCH + 1);
        update_model();
        cmp_all("R4 corrected codes");
        repeat (5) @(negedge clk);
        chk("R10 held load no restart", int'(busy), 0);
        load = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h1D5A_0C37));
        for (int i = 0; i < NCH; i++) begin
            m_in[i] = 0; m_gain[i] = 16'h3FFE; m_off[i] = 16'h2000; m_dac[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state
        cmp_all("R3 reset codes");
        chk("R3 busy", int'(busy), 0);
        chk("R3 flags", int'(addr_err | sfr_wr), 0);
        do_load();   // R3: default gain/offset give code equal to input (all 0)

        // R1: default gain/offset pass the data through, outputs wait for load
        wr(3, 3, 12345);
        wr(39, 3, 777);
        repeat (3) @(negedge clk);
        cmp_all("R1 R8 no change before load");
        do_load();
        chk("R1 ch3 passthrough", int'(dac_codes[3*DW +: DW]), 12345);

        // R2: gain bit 0 dropped: gain 1 stored as 0 -> (2*16383)>>14 = 1
        wr(5, 1, 1);
        wr(5, 2, 16'h2000);
        wr(5, 3, 16383);
        // R4: clamp high on ch6, clamp low on ch7
        wr(6, 2, 16383);
        wr(6, 3, 16383);
        wr(7, 2, 0);
        wr(7, 3, 0);
        wr(8, 2, 0);
        wr(8, 3, 100);
        do_load();
        chk("R2 gain lsb forced 0", int'(dac_codes[5*DW +: DW]), 1);
        chk("R4 clamp high", int'(dac_codes[6*DW +: DW]), 16383);
        chk("R4 clamp low", int'(dac_codes[7*DW +: DW]), 0);

        // R6 / R5: missing channels and select 00 leave channels untouched
        wr(40, 3, 999);
        wr(63, 2, 5);
        wr(2, 0, 4321);
        wr(50, 0, 1);
        do_load();
        cmp_all("R5 R6 no channel change");

        // R9: two load rises during a pass, ch0 rewritten after first pass used it
        @(negedge clk);
        load = 1'b1;
        n = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (busy) n++;
            if (k == 2 || k == 4) load = 1'b0;
            if (k == 3 || k == 5) load = 1'b1;
            if (k == 6) begin
                wr_en = 1'b1; wr_chan = '0; wr_sel = 2'b11; wr_data = DW'(9000);
            end
            if (k == 7) wr_en = 1'b0;
        end
        m_in[0] = 9000;
        @(negedge clk);
        while (busy) begin
            n++;
            @(negedge clk);
        end
        load = 1'b0;
        chk("R9 double pass length", n, 2 * (NCH + 1));
        update_model();
        cmp_all("R9 queued pass result");

        // random mix
        for (int r = 0; r < 6; r++) begin
            for (int w = 0; w < 30; w++) begin
                wr(int'($urandom_range(47, 0)), int'($urandom_range(3, 0)),
                   int'($urandom_range(16383, 0)));
            end
            cmp_all("R8 stable before load");
            do_load();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule